// File: doc/BRIEF.md
# Real-Mode Control-Transfer Stack Sequencer

This block performs the stack traffic behind control transfers of a 16-bit segmented core running in real-address mode. The core hands it one command together with the current SS, SP, CS, IP and FLAGS values, plus a target IP and CS for calls and a vector number for interrupt entry. The block then runs the matching series of 16-bit memory accesses through a request/ready word port. When the series is complete it presents the updated SP, IP, CS and FLAGS and pulses `done`.

Six command codes are defined on `cmd_op`: 0 near call, 1 far call, 2 near return, 3 far return, 4 interrupt entry, 5 interrupt return. Every memory address is a 20-bit physical address. It is formed by shifting a 16-bit segment left by four bits and adding a 16-bit offset. Stack accesses use SS with SP as the offset. Interrupt vectors are read from a table of 4-byte entries that starts at physical address zero.

Top module: `rm_xfer_seq`

## Requirements
- R1: A command is accepted when `cmd_valid` is high, `busy` is low and `cmd_op` is 0 to 5. After acceptance, `busy` is high from the next cycle until the sequence ends. At the end, `done` is high for exactly one cycle and `busy` is low in that cycle.
- R2: A command code of 6 or 7 is ignored: no request is issued and `busy` stays low. A command presented while `busy` is high is ignored and does not alter the running sequence or its results.
- R3: Every address equals (segment × 16 + offset) mod 2^20. Stack accesses use SS as the segment and SP as the offset.
- R4: A push first lowers SP by 2 and then writes at the new SP. A pop reads at SP and then raises SP by 2. SP wraps modulo 2^16.
- R5: A near call writes the return IP as one word. It finishes with IP equal to the target IP and with CS and FLAGS unchanged.
- R6: A far call pushes CS and then the return IP. It finishes with IP and CS equal to the target values.
- R7: A near return pops IP only. A far return pops IP and then CS.
- R8: Interrupt entry pushes the original FLAGS, then CS, then the return IP. The final FLAGS has bit 9 (interrupt enable) and bit 8 (trap) cleared and every other bit kept.
- R9: After its three pushes, interrupt entry reads the new IP at physical address 4 × vector and the new CS at 4 × vector + 2.
- R10: Interrupt return pops IP, then CS, then FLAGS, and restores all three.
- R11: A request holds `mem_addr`, `mem_we` and `mem_wdata` steady until `mem_ready`. A sequence of N accesses with W total wait cycles raises `done` 2N + W + 1 cycles after the accepting edge.
- R12: While reset is applied and after it is released, `busy`, `done` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (0..5) |
| cmd_vec | input | 8 | Interrupt vector number |
| cmd_ss | input | 16 | Current stack segment |
| cmd_sp | input | 16 | Current stack pointer |
| cmd_cs | input | 16 | Current code segment |
| cmd_ip | input | 16 | Return instruction pointer |
| cmd_flags | input | 16 | Current flags word |
| cmd_tgt_ip | input | 16 | Call target IP |
| cmd_tgt_cs | input | 16 | Far call target CS |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| res_sp | output | 16 | Resulting stack pointer |
| res_ip | output | 16 | Resulting instruction pointer |
| res_cs | output | 16 | Resulting code segment |
| res_flags | output | 16 | Resulting flags word |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | 20 | Physical word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with ready |
| mem_ready | input | 1 | Access completes on this edge |

## Verification
`busy` rises one cycle after the accepting edge. The first request appears one cycle later. Each later request appears one cycle after the edge that completed the previous access, and `done` follows the final completion by one cycle. The bench drives and samples on the falling edge. It counts the wait cycles it inserts with its own adjustable ready latency, then requires `done` exactly 2N + W + 1 falling edges after acceptance. On every falling edge where an access is about to complete, the bench compares the access against the next entry of an access list it predicted in advance, and it checks the result registers in the `done` cycle.

// File: rtl/rm_xfer_pkg.sv
package rm_xfer_pkg;

  typedef enum logic [2:0] {
    OP_NCALL = 3'd0,
    OP_FCALL = 3'd1,
    OP_NRET  = 3'd2,
    OP_FRET  = 3'd3,
    OP_INT   = 3'd4,
    OP_IRET  = 3'd5
  } xfer_op_e;

  typedef enum logic [3:0] {
    ST_END,
    ST_PUSH_FL,
    ST_PUSH_CS,
    ST_PUSH_IP,
    ST_POP_IP,
    ST_POP_CS,
    ST_POP_FL,
    ST_VEC_IP,
    ST_VEC_CS
  } step_e;

  localparam int STEP_IDX_W = 3;
  localparam logic [2:0] OP_LAST = 3'd5;

  function automatic logic is_push(step_e s);
    return (s == ST_PUSH_FL) || (s == ST_PUSH_CS) || (s == ST_PUSH_IP);
  endfunction

  function automatic logic is_pop(step_e s);
    return (s == ST_POP_IP) || (s == ST_POP_CS) || (s == ST_POP_FL);
  endfunction

  function automatic logic is_vec(step_e s);
    return (s == ST_VEC_IP) || (s == ST_VEC_CS);
  endfunction

endpackage

// File: rtl/rm_phys_addr.sv
module rm_phys_addr #(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 20,
  parameter int SEG_SHIFT = 4
) (
  input  logic [DATA_W-1:0] seg,
  input  logic [DATA_W-1:0] off,
  output logic [ADDR_W-1:0] phys
);
  localparam int PAD = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] ofs;

  // segment becomes a shifted base; the sum wraps at 2^ADDR_W
  assign base = {{PAD{1'b0}}, seg} << SEG_SHIFT;
  assign ofs  = {{PAD{1'b0}}, off};
  assign phys = base + ofs;
endmodule

// File: rtl/rm_step_plan.sv
module rm_step_plan
  import rm_xfer_pkg::*;
(
  input  xfer_op_e                op,
  input  logic [STEP_IDX_W-1:0]   idx,
  output step_e                   step
);
  always_comb begin
    step = ST_END;
    case (op)
      OP_NCALL: if (idx == 3'd0) step = ST_PUSH_IP;
      OP_FCALL: begin
        case (idx)
          3'd0:    step = ST_PUSH_CS;
          3'd1:    step = ST_PUSH_IP;
          default: step = ST_END;
        endcase
      end
      OP_NRET:  if (idx == 3'd0) step = ST_POP_IP;
      OP_FRET: begin
        case (idx)
          3'd0:    step = ST_POP_IP;
          3'd1:    step = ST_POP_CS;
          default: step = ST_END;
        endcase
      end
      OP_INT: begin
        case (idx)
          3'd0:    step = ST_PUSH_FL;
          3'd1:    step = ST_PUSH_CS;
          3'd2:    step = ST_PUSH_IP;
          3'd3:    step = ST_VEC_IP;
          3'd4:    step = ST_VEC_CS;
          default: step = ST_END;
        endcase
      end
      OP_IRET: begin
        case (idx)
          3'd0:    step = ST_POP_IP;
          3'd1:    step = ST_POP_CS;
          3'd2:    step = ST_POP_FL;
          default: step = ST_END;
        endcase
      end
      default: step = ST_END;
    endcase
  end
endmodule

// File: rtl/rm_xfer_seq.sv
module rm_xfer_seq
  import rm_xfer_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 20,
  parameter int SEG_SHIFT = 4,
  parameter int VEC_W     = 8,
  parameter int VEC_SHIFT = 2,
  parameter int IF_BIT    = 9,
  parameter int TF_BIT    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [VEC_W-1:0]  cmd_vec,
  input  logic [DATA_W-1:0] cmd_ss,
  input  logic [DATA_W-1:0] cmd_sp,
  input  logic [DATA_W-1:0] cmd_cs,
  input  logic [DATA_W-1:0] cmd_ip,
  input  logic [DATA_W-1:0] cmd_flags,
  input  logic [DATA_W-1:0] cmd_tgt_ip,
  input  logic [DATA_W-1:0] cmd_tgt_cs,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] res_sp,
  output logic [DATA_W-1:0] res_ip,
  output logic [DATA_W-1:0] res_cs,
  output logic [DATA_W-1:0] res_flags,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready
);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam logic [DATA_W-1:0] WSTEP = DATA_W'(WORD_BYTES);
  localparam logic [DATA_W-1:0] FLAG_CLR =
    ~((DATA_W'(1) << IF_BIT) | (DATA_W'(1) << TF_BIT));

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_WAIT} state_e;

  state_e                 state;
  xfer_op_e               op_q;
  logic [STEP_IDX_W-1:0]  idx_q;
  logic [VEC_W-1:0]       vec_q;
  logic [DATA_W-1:0]      ss_q, sp_q, cs_q, ip_q, fl_q, tip_q, tcs_q;

  step_e                  step;
  logic [DATA_W-1:0]      seg_sel, off_sel, push_data;
  logic [ADDR_W-1:0]      phys;
  logic                   op_ok;

  assign op_ok = (cmd_op <= OP_LAST);

  rm_step_plan u_plan (
    .op   (op_q),
    .idx  (idx_q),
    .step (step)
  );

  rm_phys_addr #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .SEG_SHIFT (SEG_SHIFT)
  ) u_phys (
    .seg  (seg_sel),
    .off  (off_sel),
    .phys (phys)
  );

  // one shared adder: stack pushes use SP-2, pops use SP, vectors use 4n(+2)
  always_comb begin
    seg_sel = ss_q;
    off_sel = sp_q;
    if (is_push(step)) begin
      off_sel = sp_q - WSTEP;
    end else if (is_vec(step)) begin
      seg_sel = '0;
      off_sel = (DATA_W'(vec_q) << VEC_SHIFT) + ((step == ST_VEC_CS) ? WSTEP : '0);
    end
  end

  always_comb begin
    case (step)
      ST_PUSH_FL: push_data = fl_q;
      ST_PUSH_CS: push_data = cs_q;
      default:    push_data = ip_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      busy      <= 1'b0;
      done      <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      op_q      <= OP_NCALL;
      idx_q     <= '0;
      vec_q     <= '0;
      ss_q      <= '0;
      sp_q      <= '0;
      cs_q      <= '0;
      ip_q      <= '0;
      fl_q      <= '0;
      tip_q     <= '0;
      tcs_q     <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (cmd_valid && op_ok) begin
            op_q  <= xfer_op_e'(cmd_op);
            idx_q <= '0;
            vec_q <= cmd_vec;
            ss_q  <= cmd_ss;
            sp_q  <= cmd_sp;
            cs_q  <= cmd_cs;
            ip_q  <= cmd_ip;
            fl_q  <= cmd_flags;
            tip_q <= cmd_tgt_ip;
            tcs_q <= cmd_tgt_cs;
            busy  <= 1'b1;
            state <= S_RUN;
          end
        end
        S_RUN: begin
          if (step == ST_END) begin
            if (op_q == OP_NCALL || op_q == OP_FCALL) ip_q <= tip_q;
            if (op_q == OP_FCALL) cs_q <= tcs_q;
            busy  <= 1'b0;
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            mem_req   <= 1'b1;
            mem_we    <= is_push(step);
            mem_addr  <= phys;
            mem_wdata <= push_data;
            if (is_push(step)) sp_q <= off_sel;
            if (step == ST_PUSH_FL) fl_q <= fl_q & FLAG_CLR;
            state <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (mem_ready) begin
            mem_req <= 1'b0;
            idx_q   <= idx_q + 1'b1;
            if (is_pop(step)) sp_q <= sp_q + WSTEP;
            case (step)
              ST_POP_IP, ST_VEC_IP: ip_q <= mem_rdata;
              ST_POP_CS, ST_VEC_CS: cs_q <= mem_rdata;
              ST_POP_FL:            fl_q <= mem_rdata;
              default: ;
            endcase
            state <= S_RUN;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign res_sp    = sp_q;
  assign res_ip    = ip_q;
  assign res_cs    = cs_q;
  assign res_flags = fl_q;
endmodule

// File: rtl/rm_xfer_seq_chk.sv
module rm_xfer_seq_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic              busy,
  input logic              done,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ready
);
  assert_accept_R1: assert property (@(posedge clk) disable iff (rst)
    (!busy && cmd_valid && cmd_op <= 3'd5) |=> busy);

  assert_done_idle_R1: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_req_in_busy_R1: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  assert_bad_op_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && cmd_valid && cmd_op > 3'd5) |=> (!busy && !mem_req));

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_reset_R12: assert property (@(posedge clk)
    rst |=> (!busy && !done && !mem_req));
endmodule

bind rm_xfer_seq rm_xfer_seq_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .busy      (busy),
  .done      (done),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ready (mem_ready)
);

// File: tb/sim_rm_xfer_seq.sv
module sim_rm_xfer_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [7:0]  cmd_vec = '0;
  logic [15:0] cmd_ss = '0, cmd_sp = '0, cmd_cs = '0, cmd_ip = '0;
  logic [15:0] cmd_flags = '0, cmd_tgt_ip = '0, cmd_tgt_cs = '0;
  logic        busy, done;
  logic [15:0] res_sp, res_ip, res_cs, res_flags;
  logic        mem_req, mem_we;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        mem_ready = 1'b0;

  typedef struct {bit we; int addr; int data;} acc_t;
  acc_t  exp_q[$];
  int    mem[int];
  int    checks = 0;
  int    errors = 0;
  int    lat_cfg = 0;
  int    wcnt = 0;
  int    waits = 0;
  string cur_tag = "R12";
  bit    finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rm_xfer_seq u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_vec(cmd_vec),
    .cmd_ss(cmd_ss), .cmd_sp(cmd_sp), .cmd_cs(cmd_cs), .cmd_ip(cmd_ip),
    .cmd_flags(cmd_flags), .cmd_tgt_ip(cmd_tgt_ip), .cmd_tgt_cs(cmd_tgt_cs),
    .busy(busy), .done(done), .res_sp(res_sp), .res_ip(res_ip), .res_cs(res_cs),
    .res_flags(res_flags), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int rd(int a);
    return mem.exists(a) ? mem[a] : 0;
  endfunction

  function automatic int phys(int seg, int off);
    return ((seg << 4) + off) & 'hFFFFF;
  endfunction

  // memory model with programmable latency; compares every completing access
  always @(negedge clk) begin
    if (rst) begin
      mem_ready = 1'b0;
      wcnt = 0;
    end else begin
      bit nr;
      nr = mem_req && (wcnt >= lat_cfg);
      mem_ready = nr;
      if (mem_req) mem_rdata = 16'(rd(int'(mem_addr)));
      if (mem_req && !nr) begin
        wcnt++;
        waits++;
      end
      if (mem_req && nr) begin
        wcnt = 0;
        if (exp_q.size() == 0) begin
          chk(1'b0, cur_tag, "unexpected access addr", mem_addr, 0);
        end else begin
          acc_t h;
          h = exp_q.pop_front();
          chk(int'(mem_addr) == h.addr, cur_tag, "access address", mem_addr, h.addr);
          chk(mem_we == h.we, cur_tag, "access direction", mem_we, h.we);
          if (h.we) chk(int'(mem_wdata) == h.data, cur_tag, "write data", mem_wdata, h.data);
          if (mem_we) mem[int'(mem_addr)] = int'(mem_wdata);
        end
      end
    end
  end

  task automatic push_e(ref int esp, input int ss, input int v);
    esp = (esp - 2) & 'hFFFF;
    exp_q.push_back('{1'b1, phys(ss, esp), v & 'hFFFF});
  endtask

  task automatic pop_e(ref int esp, input int ss, output int v);
    v = rd(phys(ss, esp));
    exp_q.push_back('{1'b0, phys(ss, esp), v});
    esp = (esp + 2) & 'hFFFF;
  endtask

  task automatic run(input string tag, input int op, input int ss, input int sp,
                     input int cs, input int ip, input int fl, input int tip,
                     input int tcs, input int vec, input int lat, input bit inject);
    int esp, eip, ecs, efl, n, k;
    esp = sp; eip = ip; ecs = cs; efl = fl;
    exp_q.delete();
    case (op)
      0: begin push_e(esp, ss, ip); eip = tip; end                        // R5
      1: begin push_e(esp, ss, cs); push_e(esp, ss, ip); eip = tip; ecs = tcs; end // R6
      2: pop_e(esp, ss, eip);                                              // R7
      3: begin pop_e(esp, ss, eip); pop_e(esp, ss, ecs); end               // R7
      4: begin                                                             // R8 R9
        push_e(esp, ss, fl);
        efl = fl & ~'h0300;
        push_e(esp, ss, cs);
        push_e(esp, ss, ip);
        eip = rd(vec * 4);
        exp_q.push_back('{1'b0, vec * 4, eip});
        ecs = rd(vec * 4 + 2);
        exp_q.push_back('{1'b0, vec * 4 + 2, ecs});
      end
      default: begin pop_e(esp, ss, eip); pop_e(esp, ss, ecs); pop_e(esp, ss, efl); end // R10
    endcase
    n = exp_q.size();
    @(negedge clk);
    chk(busy == 1'b0, "R1", "idle before command", busy, 0);
    cur_tag = tag;
    lat_cfg = lat;
    waits = 0;
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_vec = 8'(vec);
    cmd_ss = 16'(ss); cmd_sp = 16'(sp); cmd_cs = 16'(cs); cmd_ip = 16'(ip);
    cmd_flags = 16'(fl); cmd_tgt_ip = 16'(tip); cmd_tgt_cs = 16'(tcs);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 1'b1, "R1", "busy after accept", busy, 1);
    k = 0;
    while (!done && k < 1000) begin
      @(negedge clk);
      k++;
      if (inject && k == 1) begin  // R2: command while busy must be ignored
        cmd_valid = 1'b1; cmd_op = 3'd5; cmd_sp = 16'h0BAD; cmd_ss = 16'h0BAD;
      end else begin
        cmd_valid = 1'b0;
      end
      if (!done) chk(busy == 1'b1, "R1", "busy during sequence", busy, 1);
    end
    cmd_valid = 1'b0;
    chk(k == 2 * n + 1 + waits, "R11", "cycles to done", k, 2 * n + 1 + waits);
    chk(busy == 1'b0, "R1", "busy low with done", busy, 0);
    chk(exp_q.size() == 0, tag, "accesses left over", exp_q.size(), 0);
    chk(int'(res_sp) == esp, tag, "result SP", res_sp, esp);
    chk(int'(res_ip) == eip, tag, "result IP", res_ip, eip);
    chk(int'(res_cs) == ecs, tag, "result CS", res_cs, ecs);
    chk(int'(res_flags) == efl, tag, "result FLAGS", res_flags, efl);
    @(negedge clk);
    chk(done == 1'b0, "R1", "done lasts one cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && mem_req == 0, "R12", "outputs in reset",
        {busy, done, mem_req}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0 && done == 0 && mem_req == 0, "R12", "outputs after reset",
        {busy, done, mem_req}, 0);

    run("R5/R3/R4", 0, 'h1234, 'h0100, 'h2000, 'h0456, 'h0002, 'h9000, 0, 0, 0, 0);
    run("R7 near", 2, 'h1234, 'h00FE, 'h2000, 'h9000, 'h0002, 0, 0, 0, 2, 0);
    run("R6/R4 wrap", 1, 'h3000, 'h0000, 'h4000, 'h0111, 'h0046, 'h0222, 'h5000, 0, 1, 0);
    run("R7 far", 3, 'h3000, 'hFFFC, 'h5000, 'h0222, 'h0046, 0, 0, 0, 0, 0);

    mem['h84] = 'hBEEF; mem['h86] = 'hF000;
    run("R8/R9/R2", 4, 'h0700, 'h0200, 'h1800, 'h0333, 'h0302, 0, 0, 'h21, 0, 1);
    run("R10", 5, 'h0700, 'h01FA, 'hF000, 'hBEEF, 'h0002, 0, 0, 0, 1, 0);

    mem['h3FC] = 'h1357; mem['h3FE] = 'h2468;
    run("R9 top vector", 4, 'h0010, 'h0040, 'h0C00, 'h0777, 'h0F00, 0, 0, 'hFF, 3, 0);

    mem['h0] = 'h1111;
    run("R3 wrap", 2, 'hFFFF, 'h0010, 'h0001, 'h0002, 'h0000, 0, 0, 0, 0, 0);

    mem['h2FFFE] = 'hAAAA; mem['h20000] = 'hBBBB; mem['h20002] = 'h08D5;
    run("R10/R4 wrap", 5, 'h2000, 'hFFFE, 'h0001, 'h0002, 'h0000, 0, 0, 0, 0, 0);

    // R2: reserved codes are ignored
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd6;
    @(negedge clk);
    cmd_op = 3'd7;
    chk(busy == 0 && mem_req == 0, "R2", "code 6 ignored", {busy, mem_req}, 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 0 && mem_req == 0, "R2", "code 7 ignored", {busy, mem_req}, 0);
    @(negedge clk);
    chk(busy == 0 && mem_req == 0 && done == 0, "R2", "still idle",
        {busy, mem_req, done}, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired in %s actual=%0d expected=%0d", cur_tag, 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule